// File: doc/BRIEF.md
# Receive DMA Channel Controller

This block holds the configuration word of one receive DMA channel and sequences that channel. A single 32-bit word is written to it. The controller decodes that word into four settings:

- a channel mode, which is stop, drain-then-stop or run;
- a ring size exponent;
- a receive buffer size;
- an interrupt destination, together with a buffer-close timeout.

It tells the receive datapath whether it may begin new frames. It tracks whether a frame is still in flight, and it raises an idle status bit once the channel has fully stopped.

A quiet-period timer watches the buffer that is currently open. Each data beat written into that buffer restarts the timer. The timer counts a microsecond tick input in units of 32 ticks. When it runs out while the buffer holds data, the controller closes the buffer with a one-cycle pulse. It also pulses the host interrupt if the destination field selects the host. Software stops the channel by writing all zeros and then polls the idle bit.

Top module: `rxdma_chan_ctrl`

## Requirements
- R1: Configuration bits 31:30 select the mode: 2'b10 runs the channel (`chan_run`=1). 2'b01 drains the current frame, and both 2'b00 and 2'b11 stop it; in these three modes `chan_run`=0. A written word takes effect on the cycle after the write.
- R2: `cfg_rd_data` returns the last written word with bits 29:24, 19:18, 15:14 and 3:0 forced to zero, which is the word ANDed with 32'hC0F33FF0. After reset it reads zero.
- R3: `ring_log2` equals configuration bits 23:20. `buf_kbytes` gives the buffer size in kilobytes from bits 17:16: code 0 gives 4, 1 gives 8, 2 gives 12 and 3 gives 16.
- R4: `host_irq` pulses in the same cycle as `tmo_close`, but only when bits 13:12 hold 2'b01. With any other value it stays low.
- R5: `stat_rd_data` has bit 24 equal to `chan_idle` and all other bits zero. `chan_idle` is 1 when the mode is not run and no frame is in flight.
- R6: In drain mode (2'b01), a frame already in flight continues until `frm_end`, and `chan_idle` stays 0 until then. A `frm_start` is ignored in every mode other than run.
- R7: In stop mode (2'b00 or 2'b11), an in-flight frame is dropped and `chan_idle` reads 1 on the cycle after the mode takes effect.
- R8: After a `beat_wr`, if no further beat, `buf_done` or configuration change intervenes, `tmo_close` pulses for one cycle. The pulse comes on the cycle after the `us_tick` that brings the tick count to 32 times bits 11:4.
- R9: Every `beat_wr` restarts the quiet-period count from zero, so beats arriving more often than the timeout never cause a close.
- R10: A timeout field (bits 11:4) of zero disables the timed close.
- R11: `buf_done`, which signals that the datapath closed a full buffer, cancels any pending timed close. It takes priority over a `beat_wr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Stored configuration, reserved bits zero |
| stat_rd_data | output | 32 | Status word, bit 24 = idle |
| frm_start | input | 1 | Datapath begins a frame |
| frm_end | input | 1 | Datapath finishes the current frame |
| beat_wr | input | 1 | Data beat written into the open buffer |
| buf_done | input | 1 | Datapath closed a full buffer |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| chan_run | output | 1 | Datapath may accept new frames |
| chan_idle | output | 1 | Channel fully stopped |
| ring_log2 | output | 4 | Descriptor ring size exponent |
| buf_kbytes | output | 5 | Receive buffer size in kilobytes |
| tmo_close | output | 1 | Pulse: close the partially filled buffer |
| host_irq | output | 1 | Pulse: interrupt the host |

## Verification
A corrupted frame-in-flight flag shows up as `chan_idle` being wrong. In drain mode this appears one cycle after the `frm_end` that should have cleared the flag, and in stop mode one cycle after the mode write. A wrong quiet-period count or fill flag shows up as `tmo_close` arriving a tick early, arriving late, arriving twice or never arriving. Such an error can stay hidden for up to 32 times the timeout field in ticks, so the bench compares every output against a reference model on every cycle. It also counts the close and interrupt pulses over each window.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam int CFG_W   = 32;
  localparam int TMO_W   = 8;
  localparam int IDLE_BIT = 24;

  localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 32'hC0F3_3FF0;

  typedef enum logic [1:0] {
    CH_STOP     = 2'b00,
    CH_DRAIN    = 2'b01,
    CH_RUN      = 2'b10,
    CH_STOP_ALT = 2'b11
  } ch_mode_e;

  typedef struct packed {
    ch_mode_e         mode;
    logic [3:0]       ring_log2;
    logic [1:0]       bsz_code;
    logic [1:0]       irq_dest;
    logic [TMO_W-1:0] tmo_units;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.mode      = ch_mode_e'(w[31:30]);
    c.ring_log2 = w[23:20];
    c.bsz_code  = w[17:16];
    c.irq_dest  = w[13:12];
    c.tmo_units = w[11:4];
    return c;
  endfunction

  function automatic logic [4:0] bsz_kbytes(input logic [1:0] code);
    return ({3'b000, code} + 5'd1) << 2;
  endfunction

  function automatic logic mode_is_stop(input ch_mode_e m);
    return (m == CH_STOP) || (m == CH_STOP_ALT);
  endfunction

endpackage

// File: rtl/rxdma_cfg_reg.sv
module rxdma_cfg_reg
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_word,
  output cfg_t             cfg
);

  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= wr_data & CFG_KEEP_MASK;
    end
  end

  assign cfg_word = word_q;
  assign cfg      = decode_cfg(word_q);

endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq
  import rxdma_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ch_mode_e mode,
  input  logic     frm_start,
  input  logic     frm_end,
  output logic     run,
  output logic     idle,
  output logic     in_frame,
  output logic     start_ok,
  output logic     abort
);

  logic in_frame_q;

  assign run      = (mode == CH_RUN);
  assign start_ok = frm_start && run;
  assign abort    = mode_is_stop(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
    end else if (abort) begin
      in_frame_q <= 1'b0;
    end else if (frm_end) begin
      in_frame_q <= 1'b0;
    end else if (start_ok) begin
      in_frame_q <= 1'b1;
    end
  end

  assign in_frame = in_frame_q;
  assign idle     = !run && !in_frame_q;

endmodule

// File: rtl/rxdma_tmo.sv
module rxdma_tmo
  import rxdma_pkg::*;
#(
  parameter int US_PER_UNIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] tmo_units,
  input  logic             irq_en,
  input  logic             beat,
  input  logic             buf_done,
  input  logic             us_tick,
  output logic             fill,
  output logic             expire,
  output logic             close_pulse,
  output logic             irq_pulse
);

  localparam int CNT_W = TMO_W + $clog2(US_PER_UNIT) + 1;

  function automatic logic [CNT_W-1:0] tick_limit(input logic [TMO_W-1:0] u);
    return CNT_W'(u) * CNT_W'(US_PER_UNIT);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             fill_q;
  logic             armed;
  logic [CNT_W-1:0] cnt_inc;

  assign armed   = fill_q && (tmo_units != '0);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign expire  = armed && us_tick && !beat && !buf_done &&
                   (cnt_inc >= tick_limit(tmo_units));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      cnt_q  <= '0;
    end else if (buf_done) begin
      fill_q <= 1'b0;
      cnt_q  <= '0;
    end else if (beat) begin
      fill_q <= 1'b1;
      cnt_q  <= '0;
    end else if (expire) begin
      fill_q <= 1'b0;
      cnt_q  <= '0;
    end else if (armed && us_tick) begin
      cnt_q  <= cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      close_pulse <= 1'b0;
      irq_pulse   <= 1'b0;
    end else begin
      close_pulse <= expire;
      irq_pulse   <= expire && irq_en;
    end
  end

  assign fill = fill_q;

endmodule

// File: rtl/rxdma_chan_ctrl.sv
module rxdma_chan_ctrl
  import rxdma_pkg::*;
#(
  parameter int US_PER_UNIT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  output logic [31:0] stat_rd_data,
  input  logic        frm_start,
  input  logic        frm_end,
  input  logic        beat_wr,
  input  logic        buf_done,
  input  logic        us_tick,
  output logic        chan_run,
  output logic        chan_idle,
  output logic [3:0]  ring_log2,
  output logic [4:0]  buf_kbytes,
  output logic        tmo_close,
  output logic        host_irq
);

  cfg_t cfg;
  logic in_frame;
  logic start_ok;
  logic abort;
  logic buf_fill;
  logic tmo_expire;

  rxdma_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .cfg_word (cfg_rd_data),
    .cfg      (cfg)
  );

  rxdma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cfg.mode),
    .frm_start (frm_start),
    .frm_end   (frm_end),
    .run       (chan_run),
    .idle      (chan_idle),
    .in_frame  (in_frame),
    .start_ok  (start_ok),
    .abort     (abort)
  );

  rxdma_tmo #(.US_PER_UNIT(US_PER_UNIT)) u_tmo (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmo_units   (cfg.tmo_units),
    .irq_en      (cfg.irq_dest == 2'b01),
    .beat        (beat_wr),
    .buf_done    (buf_done),
    .us_tick     (us_tick),
    .fill        (buf_fill),
    .expire      (tmo_expire),
    .close_pulse (tmo_close),
    .irq_pulse   (host_irq)
  );

  always_comb begin
    stat_rd_data           = '0;
    stat_rd_data[IDLE_BIT] = chan_idle;
  end

  assign ring_log2  = cfg.ring_log2;
  assign buf_kbytes = bsz_kbytes(cfg.bsz_code);

endmodule

// File: rtl/rxdma_chan_ctrl_chk.sv
module rxdma_chan_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_rd_data,
  input logic        chan_run,
  input logic        chan_idle,
  input logic        beat_wr,
  input logic        buf_done,
  input logic        tmo_close,
  input logic        host_irq,
  input logic        in_frame,
  input logic        buf_fill,
  input logic        abort
);

  // R1, R5: an idle channel never runs
  a_r5_idle_not_run: assert property (@(posedge clk) disable iff (!rst_n)
    chan_idle |-> !chan_run);

  // R6: a frame only begins while the channel runs
  a_r6_start_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(chan_run));

  // R7: stop mode drops the frame in flight
  a_r7_stop_drops_frame: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !in_frame);

  // R4: the interrupt only accompanies a close
  a_r4_irq_with_close: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> tmo_close);

  // R8: the close is a single-cycle pulse
  a_r8_close_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_close |=> !tmo_close);

  // R9: a beat reopens the count and blocks a close on the next cycle
  a_r9_beat_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_wr && !buf_done) |=> (buf_fill && !tmo_close));

  // R10: a zero timeout never closes
  a_r10_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[11:4] == 8'd0) |=> !tmo_close);

  // R11: a full-buffer close clears the partial state
  a_r11_done_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> (!buf_fill && !tmo_close));

endmodule

bind rxdma_chan_ctrl rxdma_chan_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rd_data (cfg_rd_data),
  .chan_run    (chan_run),
  .chan_idle   (chan_idle),
  .beat_wr     (beat_wr),
  .buf_done    (buf_done),
  .tmo_close   (tmo_close),
  .host_irq    (host_irq),
  .in_frame    (in_frame),
  .buf_fill    (buf_fill),
  .abort       (abort)
);

// File: tb/rxdma_chan_ctrl_bench.sv
module rxdma_chan_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [31:0] stat_rd_data;
  logic        frm_start = 1'b0;
  logic        frm_end = 1'b0;
  logic        beat_wr = 1'b0;
  logic        buf_done = 1'b0;
  logic        us_tick = 1'b0;
  logic        chan_run;
  logic        chan_idle;
  logic [3:0]  ring_log2;
  logic [4:0]  buf_kbytes;
  logic        tmo_close;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_chan_ctrl u_rxdma_chan_ctrl (
    .clk (clk), .rst_n (rst_n),
    .cfg_wr_en (cfg_wr_en), .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data), .stat_rd_data (stat_rd_data),
    .frm_start (frm_start), .frm_end (frm_end),
    .beat_wr (beat_wr), .buf_done (buf_done), .us_tick (us_tick),
    .chan_run (chan_run), .chan_idle (chan_idle),
    .ring_log2 (ring_log2), .buf_kbytes (buf_kbytes),
    .tmo_close (tmo_close), .host_irq (host_irq)
  );

  // Behavioural reference model
  int unsigned m_cfg = 0;
  bit m_busy = 0;
  bit m_part = 0;
  int m_ticks = 0;
  bit m_close = 0;
  bit m_irq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_busy = 0; m_part = 0; m_ticks = 0; m_close = 0; m_irq = 0;
    end else begin
      int md;
      int units;
      bit fire;
      md    = int'(m_cfg >> 30);
      units = int'((m_cfg >> 4) % 256);
      fire  = 0;
      if (md == 0 || md == 3)       m_busy = 0;
      else if (frm_end)             m_busy = 0;
      else if (frm_start && md == 2) m_busy = 1;
      if (buf_done) begin
        m_part = 0; m_ticks = 0;
      end else if (beat_wr) begin
        m_part = 1; m_ticks = 0;
      end else if (m_part && units > 0 && us_tick) begin
        m_ticks++;
        if (m_ticks >= units * 32) begin
          fire = 1; m_part = 0; m_ticks = 0;
        end
      end
      m_close = fire;
      m_irq   = fire && (((m_cfg >> 12) % 4) == 1);
      if (cfg_wr_en) m_cfg = cfg_wr_data & 32'hC0F33FF0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  int close_seen = 0;
  int irq_seen = 0;
  int tick_div = 0;
  int cyc = 0;

  task automatic compare();
    int md;
    bit exp_idle;
    md = int'(m_cfg >> 30);
    exp_idle = (md != 2) && !m_busy;
    chk(cfg_rd_data == m_cfg, "R2 readback", cfg_rd_data, m_cfg);
    chk(chan_run == (md == 2), "R1 run", chan_run, md == 2);
    chk(ring_log2 == 4'((m_cfg >> 20) % 16), "R3 ring", ring_log2, (m_cfg >> 20) % 16);
    chk(buf_kbytes == 5'(4 * (((m_cfg >> 16) % 4) + 1)), "R3 bufsize",
        buf_kbytes, 4 * (((m_cfg >> 16) % 4) + 1));
    chk(chan_idle == exp_idle, "R5 idle", chan_idle, exp_idle);
    chk(stat_rd_data == (32'(exp_idle) << 24), "R5 status", stat_rd_data, 32'(exp_idle) << 24);
    chk(tmo_close == m_close, "R8 close", tmo_close, m_close);
    chk(host_irq == m_irq, "R4 irq", host_irq, m_irq);
    if (tmo_close) close_seen++;
    if (host_irq) irq_seen++;
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      cfg_wr_en = 0; frm_start = 0; frm_end = 0; beat_wr = 0; buf_done = 0;
      cyc++;
      us_tick = (tick_div > 0) && (cyc % tick_div == 0);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    cfg_wr_en = 1; cfg_wr_data = w; step();
  endtask

  function automatic logic [31:0] mk(input int md, input int ring, input int bsz,
                                     input int dest, input int units);
    return (32'(md) << 30) | (32'(ring) << 20) | (32'(bsz) << 16) |
           (32'(dest) << 12) | (32'(units) << 4);
  endfunction

  task automatic window(input int n, input int exp_close, input int exp_irq, input string req);
    close_seen = 0; irq_seen = 0;
    step(n);
    chk(close_seen == exp_close, req, close_seen, exp_close);
    chk(irq_seen == exp_irq, req, irq_seen, exp_irq);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // reset state: R2 zero config, R5 idle
    chk(cfg_rd_data == 0, "R2 reset", cfg_rd_data, 0);
    chk(chan_idle == 1, "R5 reset idle", chan_idle, 1);

    // R2: reserved bits dropped
    write_cfg(mk(2, 8, 1, 1, 1) | 32'h3F0C_C00F);
    step();
    chk(cfg_rd_data == mk(2, 8, 1, 1, 1), "R2 masked", cfg_rd_data, mk(2, 8, 1, 1, 1));
    chk(chan_run == 1, "R1 run mode", chan_run, 1);

    // R8: single close after 32 ticks of quiet
    tick_div = 1;
    beat_wr = 1; step();
    window(40, 1, 1, "R8 close count");

    // R9: periodic beats keep the buffer open
    for (int k = 0; k < 6; k++) begin
      beat_wr = 1; step();
      window(20, 0, 0, "R9 restart");
    end
    window(20, 1, 1, "R9 close after last beat");

    // R4: no interrupt when destination is none
    write_cfg(mk(2, 5, 2, 0, 1));
    beat_wr = 1; step();
    window(40, 1, 0, "R4 no host irq");

    // R10: zero timeout
    write_cfg(mk(2, 5, 3, 1, 0));
    beat_wr = 1; step();
    window(80, 0, 0, "R10 zero timeout");

    // R11: buf_done cancels, also wins over a beat
    write_cfg(mk(2, 12, 0, 1, 1));
    beat_wr = 1; step();
    step(10);
    buf_done = 1; step();
    window(40, 0, 0, "R11 done cancels");
    beat_wr = 1; buf_done = 1; step();
    window(40, 0, 0, "R11 done beats beat");

    // R8: slow tick, two units
    tick_div = 3;
    write_cfg(mk(2, 8, 0, 1, 2));
    beat_wr = 1; step();
    window(220, 1, 1, "R8 slow tick");
    tick_div = 0;

    // R6: drain mode finishes the frame in flight
    frm_start = 1; step();
    write_cfg(mk(1, 8, 0, 1, 0));
    step(3);
    chk(chan_idle == 0, "R6 busy while draining", chan_idle, 0);
    frm_start = 1; step(2);
    frm_end = 1; step(2);
    chk(chan_idle == 1, "R6 idle after frame end", chan_idle, 1);
    frm_start = 1; step(2);
    chk(chan_idle == 1, "R6 start ignored", chan_idle, 1);

    // R7: stop modes drop the frame
    write_cfg(mk(2, 8, 0, 1, 0));
    frm_start = 1; step();
    write_cfg(32'h0);
    step();
    chk(chan_idle == 1, "R7 stop idle", chan_idle, 1);
    write_cfg(mk(2, 8, 0, 1, 0));
    frm_start = 1; step();
    write_cfg(mk(3, 8, 0, 1, 0));
    step();
    chk(chan_idle == 1 && chan_run == 0, "R7 alt stop idle", chan_idle, 1);

    // R3: every buffer size code
    for (int b = 0; b < 4; b++) begin
      write_cfg(mk(2, 4 + b, b, 0, 0));
      step();
      chk(buf_kbytes == 5'(4 * (b + 1)), "R3 size code", buf_kbytes, 4 * (b + 1));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule